// File: doc/BRIEF.md
# Static Memory Write-Cycle Timing Generator

This block turns one write request into a single write cycle on an external static-memory bus. When idle, it accepts a request that carries a chip-select index, a word address, 32 bits of data and byte enables. It captures these values and then runs a cycle counter for a programmed number of master clock cycles. Each chip select has its own set of timing fields. The setup values are grouped in one set of ports and the pulse values in another. From the counter, the block derives the active-low chip-select strobe, the active-low write strobe, the byte qualifiers and the data-bus output enable.

A per-chip-select mode bit chooses which strobe qualifies the write. With the write strobe qualifying, the data bus is driven from the end of the write-strobe setup to the end of the cycle. With the chip select qualifying, the data bus is driven from the end of the chip-select setup to the end of the cycle, and the write-strobe waveform has no effect on it. A static byte-mode input chooses between two byte encodings. In the first, one write strobe is used together with four byte selects. In the second, there are four per-byte write strobes. A one-clock done pulse marks the last cycle.

Top module: `smw_top`

## Requirements
- R1: After reset and while idle, all chip selects, the write strobe, the byte selects and the per-byte strobes are high, data enable and done are low, and the address and data outputs are zero until the first request is captured.
- R2: A request made while idle is captured on that clock edge, and the cycle counter starts at 0 on the next cycle. The cycle lasts len cycles of the selected chip select, and a len of 0 runs for one cycle. A request made while a cycle is running is ignored.
- R3: Only the selected chip-select output goes low. It is low when the counter is at least the chip-select setup and below setup plus pulse, and only within the cycle. A pulse of 0 keeps it high.
- R4: The write strobe is low when the counter is at least the write setup and below setup plus pulse, and only within the cycle. A setup of 0 starts it in the first cycle.
- R5: When the selected mode bit is 1, data enable is high from the counter value equal to the write setup until the end of the cycle.
- R6: When the selected mode bit is 0, data enable is high from the counter value equal to the chip-select setup until the end of the cycle, whatever the write-strobe timing is.
- R7: Done is high for exactly the last cycle of each write cycle.
- R8: The address and data outputs hold the captured values, and stay unchanged for the whole cycle.
- R9: With byte_mode 0, the byte selects equal the inverted captured enables during the cycle, and the per-byte strobes stay high. With byte_mode 1, the write strobe and the byte selects stay high, and per-byte strobe b follows the write-strobe waveform when enable bit b is set.
- R10: The timing of chip select k is read from bits [k*TW +: TW] of each timing port, and its mode from bit k of the mode port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_i | input | 1 | write request |
| cs_i | input | CSW | chip-select index of the request |
| addr_i | input | AW | word address |
| data_i | input | DW | write data |
| be_i | input | DW/8 | byte enables, bit b for byte b |
| byte_mode_i | input | 1 | 0 byte selects, 1 per-byte strobes |
| wmode_i | input | NCS | per chip select: 1 write strobe qualifies, 0 chip select qualifies |
| we_setup_i | input | NCS*TW | write-strobe setup group |
| cs_setup_i | input | NCS*TW | chip-select setup group |
| we_pulse_i | input | NCS*TW | write-strobe pulse group |
| cs_pulse_i | input | NCS*TW | chip-select pulse group |
| cyc_len_i | input | NCS*TW | total cycle length |
| ncs_o | output | NCS | active-low chip selects |
| nwe_o | output | 1 | active-low write strobe |
| nbs_o | output | DW/8 | active-low byte selects |
| nwr_o | output | DW/8 | active-low per-byte write strobes |
| addr_o | output | AW | address bus |
| data_o | output | DW | data bus value |
| data_oe_o | output | 1 | data-bus output enable |
| done_o | output | 1 | last-cycle pulse |

## Verification
The bench builds the block with its defaults: two chip selects, a 24-bit word address, a 32-bit data bus and 6-bit timing fields. With two chip selects, the bench can program different timings and modes per select and check the field slicing. With 6-bit fields, it can use zero setups, zero pulses, a zero length and pulses that run past the end of the cycle in short runs. Every clock, a behavioural model compares each strobe, the byte lines, the enable window and done in both write modes and both byte modes.

// File: rtl/smw_pkg.sv
package smw_pkg;
  typedef enum logic { BYTE_SEL = 1'b0, BYTE_WR = 1'b1 } byte_mode_e;
  typedef enum logic { QUAL_CS = 1'b0, QUAL_WE = 1'b1 } wmode_e;
endpackage

// File: rtl/smw_seq.sv
module smw_seq #(
  parameter int NCS = 2,
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int TW  = 6,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BW  = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [CSW-1:0]    cs_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [BW-1:0]     be_i,
  input  logic [NCS*TW-1:0] cyc_len_i,
  output logic              busy_o,
  output logic [TW-1:0]     cnt_o,
  output logic              done_o,
  output logic [CSW-1:0]    cs_q_o,
  output logic [AW-1:0]     addr_q_o,
  output logic [DW-1:0]     data_q_o,
  output logic [BW-1:0]     be_q_o
);
  logic          busy_q, busy_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cap_en, last;
  logic [TW-1:0] len_sel;

  assign len_sel = cyc_len_i[cs_q_o*TW +: TW];
  assign last    = (len_sel == '0) || (cnt_q == len_sel - 1'b1);
  assign cap_en  = req_i && !busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end else if (req_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q_o   <= '0;
      addr_q_o <= '0;
      data_q_o <= '0;
      be_q_o   <= '0;
    end else if (cap_en) begin
      cs_q_o   <= cs_i;
      addr_q_o <= addr_i;
      data_q_o <= data_i;
      be_q_o   <= be_i;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = busy_q && last;

  // R2: a request seen while busy must not change captured state
  p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_i) |=> $stable(addr_q_o) && $stable(data_q_o));
  // R7: the cycle closes right after done
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/smw_strobe.sv
module smw_strobe #(
  parameter int TW = 6
) (
  input  logic          busy_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] pulse_i,
  output logic          act_o,
  output logic          past_setup_o
);
  logic [TW:0] end_cnt;
  assign end_cnt      = {1'b0, setup_i} + {1'b0, pulse_i};
  assign past_setup_o = busy_i && (cnt_i >= setup_i);
  assign act_o        = past_setup_o && ({1'b0, cnt_i} < end_cnt);
endmodule

// File: rtl/smw_top.sv
module smw_top #(
  parameter int NCS = 2,
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int TW  = 6,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BW  = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [CSW-1:0]    cs_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [BW-1:0]     be_i,
  input  logic              byte_mode_i,
  input  logic [NCS-1:0]    wmode_i,
  input  logic [NCS*TW-1:0] we_setup_i,
  input  logic [NCS*TW-1:0] cs_setup_i,
  input  logic [NCS*TW-1:0] we_pulse_i,
  input  logic [NCS*TW-1:0] cs_pulse_i,
  input  logic [NCS*TW-1:0] cyc_len_i,
  output logic [NCS-1:0]    ncs_o,
  output logic              nwe_o,
  output logic [BW-1:0]     nbs_o,
  output logic [BW-1:0]     nwr_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              done_o
);
  import smw_pkg::*;

  logic           busy, cs_act, we_act, cs_past, we_past, sel_mode;
  logic [TW-1:0]  cnt;
  logic [CSW-1:0] cs_q;
  logic [BW-1:0]  be_q;
  byte_mode_e     bmode;

  assign bmode = byte_mode_e'(byte_mode_i);

  smw_seq #(.NCS(NCS), .AW(AW), .DW(DW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cs_i(cs_i), .addr_i(addr_i),
    .data_i(data_i), .be_i(be_i), .cyc_len_i(cyc_len_i), .busy_o(busy),
    .cnt_o(cnt), .done_o(done_o), .cs_q_o(cs_q), .addr_q_o(addr_o),
    .data_q_o(data_o), .be_q_o(be_q)
  );

  smw_strobe #(.TW(TW)) u_cs_strb (
    .busy_i(busy), .cnt_i(cnt),
    .setup_i(cs_setup_i[cs_q*TW +: TW]), .pulse_i(cs_pulse_i[cs_q*TW +: TW]),
    .act_o(cs_act), .past_setup_o(cs_past)
  );

  smw_strobe #(.TW(TW)) u_we_strb (
    .busy_i(busy), .cnt_i(cnt),
    .setup_i(we_setup_i[cs_q*TW +: TW]), .pulse_i(we_pulse_i[cs_q*TW +: TW]),
    .act_o(we_act), .past_setup_o(we_past)
  );

  assign sel_mode  = wmode_i[cs_q];
  assign data_oe_o = (wmode_e'(sel_mode) == QUAL_WE) ? we_past : cs_past;
  assign nwe_o     = !(we_act && bmode == BYTE_SEL);
  assign nbs_o     = (busy && bmode == BYTE_SEL) ? ~be_q : '1;

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign ncs_o[k] = !(cs_act && cs_q == CSW'(k));
  end

  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign nwr_o[b] = !(we_act && bmode == BYTE_WR && be_q[b]);
  end

  // R3: never more than one chip select low
  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ncs_o) <= 1);
  // R5: in write-strobe mode a low strobe lies inside the drive window
  p_we_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mode && !nwe_o) |-> data_oe_o);
  // R8: address and data steady until the last cycle
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_o) |=> $stable(addr_o) && $stable(data_o));
  // R1: no strobe and no drive when idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!data_oe_o && nwe_o && (&ncs_o) && (&nwr_o)));
endmodule

// File: tb/smw_top_tb.sv
module smw_top_tb;
  localparam int NCS = 2, AW = 24, DW = 32, TW = 6, BW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req = 1'b0, cs = 1'b0, bmode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [BW-1:0] be = '0;
  int ws[NCS], wp[NCS], css[NCS], csp[NCS], len[NCS];
  logic [NCS-1:0] wm = '0;
  logic [NCS*TW-1:0] ws_v, wp_v, css_v, csp_v, len_v;
  always_comb
    for (int k = 0; k < NCS; k++) begin
      ws_v[k*TW +: TW] = TW'(ws[k]);  wp_v[k*TW +: TW] = TW'(wp[k]);
      css_v[k*TW +: TW] = TW'(css[k]); csp_v[k*TW +: TW] = TW'(csp[k]);
      len_v[k*TW +: TW] = TW'(len[k]);
    end

  logic [NCS-1:0] ncs_o;
  logic nwe_o, oe_o, done_o;
  logic [BW-1:0] nbs_o, nwr_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;

  smw_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cs_i(cs), .addr_i(addr), .data_i(data),
    .be_i(be), .byte_mode_i(bmode), .wmode_i(wm), .we_setup_i(ws_v), .cs_setup_i(css_v),
    .we_pulse_i(wp_v), .cs_pulse_i(csp_v), .cyc_len_i(len_v), .ncs_o(ncs_o),
    .nwe_o(nwe_o), .nbs_o(nbs_o), .nwr_o(nwr_o), .addr_o(addr_o), .data_o(data_o),
    .data_oe_o(oe_o), .done_o(done_o)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit m_busy = 0; int m_k = 0, m_cs = 0;
  logic [AW-1:0] m_addr = '0; logic [DW-1:0] m_data = '0; logic [BW-1:0] m_be = '0;

  function automatic int eff_len(int c); return (len[c] == 0) ? 1 : len[c]; endfunction

  // behavioural reference (R2: capture when idle, count to len)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_k <= 0; m_cs <= 0; m_addr <= '0; m_data <= '0; m_be <= '0;
    end else if (m_busy) begin
      if (m_k >= eff_len(m_cs) - 1) m_busy <= 0; else m_k <= m_k + 1;
    end else if (req) begin
      m_busy <= 1; m_k <= 0; m_cs <= int'(cs); m_addr <= addr; m_data <= data; m_be <= be;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    bit ca, wa, last, oe_e;
    logic [NCS-1:0] ncs_e; logic [BW-1:0] nbs_e, nwr_e; logic nwe_e;
    cycles++;
    ca = m_busy && m_k >= css[m_cs] && m_k < css[m_cs] + csp[m_cs];
    wa = m_busy && m_k >= ws[m_cs] && m_k < ws[m_cs] + wp[m_cs];
    last = m_busy && (m_k == eff_len(m_cs) - 1);
    oe_e = m_busy && (wm[m_cs] ? (m_k >= ws[m_cs]) : (m_k >= css[m_cs]));
    ncs_e = '1; if (ca) ncs_e[m_cs] = 1'b0;
    nwe_e = !(wa && !bmode);
    nbs_e = (m_busy && !bmode) ? ~m_be : '1;
    for (int b = 0; b < BW; b++) nwr_e[b] = !(wa && bmode && m_be[b]);
    if (!m_busy) begin
      chk("R1 idle strobes", {ncs_o, nwe_o, nbs_o, nwr_o, oe_o, done_o},
          {ncs_e, nwe_e, nbs_e, nwr_e, 1'b0, 1'b0});
    end else begin
      chk("R3 ncs", 64'(ncs_o), 64'(ncs_e));
      chk("R4 nwe", 64'(nwe_o), 64'(nwe_e));
      chk(wm[m_cs] ? "R5 oe write-strobe mode" : "R6 oe chip-select mode", 64'(oe_o), 64'(oe_e));
      chk("R7 done", 64'(done_o), 64'(last));
      chk("R9 byte lines", {nbs_o, nwr_o}, {nbs_e, nwr_e});
    end
    chk("R8 address/data", {addr_o, data_o}, {m_addr, m_data});
  end

  task automatic set_cs(int c, bit mode, int a, int b, int e, int f, int l);
    wm[c] = mode; ws[c] = a; wp[c] = b; css[c] = e; csp[c] = f; len[c] = l;
  endtask

  task automatic wr(int c, logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] e, bit hold);
    @(posedge clk); #2;
    req = 1; cs = c[0]; addr = a; data = d; be = e;
    @(posedge clk); #2;
    if (!hold) req = 0;
    else begin addr = ~a; data = ~d; end  // R2: held request during busy ignored
    while (m_busy) begin @(posedge clk); #2; end
    req = 0;
    @(posedge clk); #2;
  endtask

  initial begin
    for (int k = 0; k < NCS; k++) set_cs(k, 1, 1, 1, 0, 2, 4);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R10: distinct per-select timing
    set_cs(0, 1, 2, 3, 1, 5, 8);
    set_cs(1, 0, 3, 2, 1, 6, 9);
    wr(0, 24'h123456, 32'hA5A5_0001, 4'b1111, 0);
    wr(1, 24'h00ABCD, 32'h1234_5678, 4'b0011, 0);
    // R4/R5 zero setup and zero write pulse
    set_cs(0, 1, 0, 0, 0, 4, 4);
    wr(0, 24'h000001, 32'hFFFF_0000, 4'b1000, 0);
    // R2 zero length runs one cycle
    set_cs(1, 0, 0, 1, 0, 1, 0);
    wr(1, 24'h000002, 32'h0F0F_0F0F, 4'b0001, 0);
    // R9 per-byte strobes
    bmode = 1;
    set_cs(0, 1, 1, 2, 0, 4, 5);
    wr(0, 24'h0000F0, 32'hDEAD_BEEF, 4'b0101, 0);
    // R6 NWE waveform does not move the drive window
    set_cs(1, 0, 4, 1, 2, 3, 6);
    wr(1, 24'h0000F1, 32'hCAFE_0001, 4'b1010, 0);
    bmode = 0;
    // R2 request held through cycle, back to back
    set_cs(0, 1, 1, 2, 1, 3, 5);
    wr(0, 24'h0A0A0A, 32'h5555_AAAA, 4'b1100, 1);
    // R3/R4 pulses that run past the end are cut
    set_cs(0, 1, 5, 10, 3, 20, 7);
    wr(0, 24'h777777, 32'h0000_0007, 4'b1111, 0);
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule